// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-attached watchdog timer for a larger chip. Software programs it through a small register file behind a simple APB-style access port. The port is always ready, and read data is valid in the access phase. Once the watchdog is enabled, it counts a programmable power-of-two number of clock periods. At the end of that first interval it sets a sticky expiry flag and, if the interrupt stage is enabled, raises an interrupt. It then starts a second, shorter programmable interval. If software has not restarted the timer by the end of that second interval and the reset stage is enabled, the block pulses a reset-request output for one clock. The block then holds until it is restarted or disabled.

Writes to the configuration and restart registers are guarded. Software must first write the unlock key to the write-enable register, and that unlock covers exactly one protected write. A restart needs a second key value in the restart register. The block also has a read-only identification register. It has a clock-select bit that is stored and read back but drives nothing here. A parameter selects a narrow 16-bit counter variant, which caps the first-interval selector.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the configuration register reads 0, the status register reads 0, the write-enable register reads 0 (locked), and both irq_o and rst_req_o are low.
- R2: Writing 0x5AA5 to the write-enable register (byte offset 0x18) unlocks, which reads back as bit 0 of that register. Any other value written there locks again. The next write to the configuration register (0x10) or the restart register (0x14) consumes the unlock, whether or not that write had any effect.
- R3: A write to the configuration or restart register while locked is ignored: the configuration reads back unchanged and a running or expired count is not restarted.
- R4: The configuration register at 0x10 holds these fields: bit 0 is the enable, bit 1 is the clock select (stored only), bit 2 is the interrupt-stage enable, bit 3 is the reset-stage enable, bits 7:4 are the first-interval selector and bits 10:8 are the second-interval selector. All other bits read 0.
- R5: Once enabled, the first interval lasts 2^n clock periods. The selector values 0 to 15 pick n in turn from 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29 and 31. When the interval ends, irq_o goes high if the interrupt stage is enabled. irq_o is never high while the enable or the interrupt-stage enable is 0.
- R6: Status bit 0 (offset 0x1C) is set when the first interval ends, even with the interrupt stage disabled. It stays set until software writes 1 to it. Writing 0 has no effect.
- R7: The second interval starts when the first ends and lasts 2^(s+7) clock periods, where s is the second-interval selector (0 to 7). At its end, if the reset stage is enabled, rst_req_o is high for exactly one clock. With the reset stage disabled, rst_req_o stays low.
- R8: Writing 0xCAFE to the restart register while unlocked clears both stage counts, returns to the first stage and drops irq_o. A full first interval then follows. Any other value written there, even while unlocked, leaves the count running.
- R9: A configuration write that clears the enable stops counting and drops irq_o. No interrupt and no reset request follow.
- R10: The ID register (offset 0x00) always reads the ID_VALUE parameter. Writes to it are ignored.
- R11: With CNT_W set to 16, a first-interval selector above 7 is stored and read back as 7. With CNT_W set to 32, the selector is stored as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Select for the register port |
| penable_i | input | 1 | Access phase of the register port |
| pwrite_i | input | 1 | 1 for a write, 0 for a read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while a read is selected |
| irq_o | output | 1 | Interrupt: level, high from the first expiry until a restart or disable |
| rst_req_o | output | 1 | One-clock reset request at the second expiry |

## Verification
The assertions check the following on every cycle:
- the reset request is a single-cycle pulse that only appears with the reset stage enabled;
- the interrupt is gated by both enables;
- a locked configuration write leaves the stored fields stable;
- any protected write consumes the unlock;
- a valid restart drops the interrupt in the next cycle;
- the expiry flag follows its set and write-one-to-clear rules.

Only the bench scenarios can show the exact lengths of both intervals for different selector values and that a restart yields a full fresh first interval. They also show that a wrong restart key leaves the count running, that a disable is lasting, and that the 16-bit variant clamps its selector.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W = 32;

  localparam logic [11:0] OFF_ID  = 12'h000;
  localparam logic [11:0] OFF_CFG = 12'h010;
  localparam logic [11:0] OFF_RS  = 12'h014;
  localparam logic [11:0] OFF_WE  = 12'h018;
  localparam logic [11:0] OFF_STA = 12'h01C;

  localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0000_5AA5;
  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_CAFE;

  typedef struct packed {
    logic [2:0] rst_sel;
    logic [3:0] int_sel;
    logic       rst_en;
    logic       int_en;
    logic       clk_sel;
    logic       en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {
    ST_INT  = 2'd0,
    ST_RST  = 2'd1,
    ST_HOLD = 2'd2
  } stage_e;

  // first-stage exponent: 6, 8, then +1 up to 15, then +2 up to 31
  function automatic logic [4:0] int_exp(input logic [3:0] idx);
    int n;
    if (idx == 4'd0)      n = 6;
    else if (idx == 4'd1) n = 8;
    else if (idx < 4'd8)  n = int'(idx) + 8;
    else                  n = 17 + 2 * (int'(idx) - 8);
    return 5'(n);
  endfunction

  function automatic logic [4:0] rst_exp(input logic [2:0] idx);
    return 5'({2'b00, idx}) + 5'd7;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          MAX_INT_IDX = 15,
  parameter logic [31:0] ID_VALUE    = 32'h0057_D200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic              expire_i,
  output cfg_t              cfg_o,
  output logic              restart_o,
  output logic              unlock_o,
  output logic              wr_cfg_o,
  output logic              wr_rs_o,
  output logic              sta_w1c_o,
  output logic              flag_o
);

  localparam logic [3:0] MAX_SEL = 4'(MAX_INT_IDX);

  logic wr_acc;
  logic hit_id, hit_cfg, hit_rs, hit_we, hit_sta;
  logic wr_we, wr_sta;
  logic unlock_q, flag_q;
  cfg_t cfg_q, cfg_new;

  assign wr_acc  = psel_i & penable_i & pwrite_i;
  assign hit_id  = (paddr_i == OFF_ID[ADDR_W-1:0]);
  assign hit_cfg = (paddr_i == OFF_CFG[ADDR_W-1:0]);
  assign hit_rs  = (paddr_i == OFF_RS[ADDR_W-1:0]);
  assign hit_we  = (paddr_i == OFF_WE[ADDR_W-1:0]);
  assign hit_sta = (paddr_i == OFF_STA[ADDR_W-1:0]);

  assign wr_cfg_o  = wr_acc & hit_cfg;
  assign wr_rs_o   = wr_acc & hit_rs;
  assign wr_we     = wr_acc & hit_we;
  assign wr_sta    = wr_acc & hit_sta;
  assign sta_w1c_o = wr_sta & pwdata_i[0];
  assign restart_o = wr_rs_o & unlock_q & (pwdata_i == RESTART_KEY);

  always_comb begin
    cfg_new = cfg_t'(pwdata_i[CFG_W-1:0]);
    if (cfg_new.int_sel > MAX_SEL) cfg_new.int_sel = MAX_SEL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      cfg_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_we)                   unlock_q <= (pwdata_i == UNLOCK_KEY);
      else if (wr_cfg_o | wr_rs_o) unlock_q <= 1'b0;

      if (wr_cfg_o && unlock_q) cfg_q <= cfg_new;

      // set wins over clear
      if (expire_i)       flag_q <= 1'b1;
      else if (sta_w1c_o) flag_q <= 1'b0;
    end
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      if (hit_id)  prdata_o = ID_VALUE;
      if (hit_cfg) prdata_o[CFG_W-1:0] = cfg_q;
      if (hit_we)  prdata_o[0] = unlock_q;
      if (hit_sta) prdata_o[0] = flag_q;
    end
  end

  assign cfg_o    = cfg_q;
  assign unlock_o = unlock_q;
  assign flag_o   = flag_q;

endmodule

// File: rtl/wdt_stage_timer.sv
module wdt_stage_timer #(
  parameter int CNT_W = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [4:0] exp_i,
  output logic       term_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // 2^exp - 1; >= keeps a shortened interval from wrapping
  assign last   = ~({CNT_W{1'b1}} << exp_i);
  assign term_o = run_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (term_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cfg_t       cfg_i,
  input  logic       restart_i,
  input  logic [1:0] term_i,
  output logic [1:0] run_o,
  output logic [1:0] clr_o,
  output logic       expire_o,
  output logic       irq_o,
  output logic       rst_req_o
);

  stage_e stage_q;
  logic   rst_req_q;
  logic   halt;

  assign halt     = ~cfg_i.en | restart_i;
  assign run_o[0] = ~halt & (stage_q == ST_INT);
  assign run_o[1] = ~halt & (stage_q == ST_RST);
  assign clr_o[0] = halt | (stage_q != ST_INT);
  assign clr_o[1] = halt | (stage_q != ST_RST);
  assign expire_o = term_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_INT;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (halt) begin
        stage_q <= ST_INT;
      end else begin
        unique case (stage_q)
          ST_INT:  if (term_i[0]) stage_q <= ST_RST;
          ST_RST:  if (term_i[1]) begin
                     stage_q   <= ST_HOLD;
                     rst_req_q <= cfg_i.rst_en;
                   end
          default: stage_q <= ST_HOLD;
        endcase
      end
    end
  end

  assign irq_o     = cfg_i.en & cfg_i.int_en & (stage_q != ST_INT);
  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h0057_D200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  // CNT_W of 16 or more; below 32 the first-stage selector tops out at 7
  localparam int MAX_INT_IDX = (CNT_W >= 32) ? 15 : 7;
  localparam int N_STAGE     = 2;

  cfg_t       cfg_q;
  logic       restart_vld, unlock_q, wr_cfg, wr_rs, sta_w1c, flag_q;
  logic       expire_evt;
  logic [1:0] run, clr, term;
  logic [4:0] stage_exp [N_STAGE];

  assign stage_exp[0] = int_exp(cfg_q.int_sel);
  assign stage_exp[1] = rst_exp(cfg_q.rst_sel);

  wdt_regs #(
    .ADDR_W     (ADDR_W),
    .MAX_INT_IDX(MAX_INT_IDX),
    .ID_VALUE   (ID_VALUE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .expire_i  (expire_evt),
    .cfg_o     (cfg_q),
    .restart_o (restart_vld),
    .unlock_o  (unlock_q),
    .wr_cfg_o  (wr_cfg),
    .wr_rs_o   (wr_rs),
    .sta_w1c_o (sta_w1c),
    .flag_o    (flag_q)
  );

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    wdt_stage_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[g]),
      .run_i  (run[g]),
      .exp_i  (stage_exp[g]),
      .term_o (term[g])
    );
  end

  wdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_q),
    .restart_i (restart_vld),
    .term_i    (term),
    .run_o     (run),
    .clr_o     (clr),
    .expire_o  (expire_evt),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
  import wdt_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic irq_o,
  input logic rst_req_o,
  input cfg_t cfg,
  input logic unlock,
  input logic wr_cfg,
  input logic wr_rs,
  input logic restart,
  input logic expire,
  input logic sta_w1c,
  input logic flag
);

  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_rst_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(cfg.rst_en));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg.en && cfg.int_en));

  assert_locked_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !unlock) |=> $stable(cfg));

  assert_one_shot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg || wr_rs) |=> !unlock);

  assert_restart_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !irq_o);

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag);

  assert_flag_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sta_w1c && !expire) |=> !flag);

endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cfg       (cfg_q),
  .unlock    (unlock_q),
  .wr_cfg    (wr_cfg),
  .wr_rs     (wr_rs),
  .restart   (restart_vld),
  .expire    (expire_evt),
  .sta_w1c   (sta_w1c),
  .flag      (flag_q)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;

  localparam logic [31:0] ID_V = 32'h0057_D200;
  localparam logic [11:0] A_ID = 12'h000, A_CFG = 12'h010, A_RS = 12'h014,
                          A_WE = 12'h018, A_STA = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata16;
  logic        irq, rst_req, irq16, rst_req16;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_two_stage #(.CNT_W(32), .ID_VALUE(ID_V)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq), .rst_req_o(rst_req));

  wdt_two_stage #(.CNT_W(16), .ID_VALUE(ID_V)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata16), .irq_o(irq16), .rst_req_o(rst_req16));

  function automatic int int_len(input int sel);
    int e [16] = '{6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31};
    return 1 << e[sel];
  endfunction

  function automatic int rst_len(input int sel);
    return 1 << (sel + 7);
  endfunction

  function automatic logic [31:0] mk_cfg(input int isel, input int rsel,
                                         input bit ie, input bit re, input bit cs);
    return 32'(rsel << 8) | 32'(isel << 4) | {28'd0, re, ie, cs, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] d16);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata; d16 = prdata16;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic prot_wr(input logic [11:0] a, input logic [31:0] d);
    wr(A_WE, 32'h5AA5);
    wr(a, d);
  endtask

  // counts negedges until the signal is high; also notes a reset request
  task automatic wait_irq(input int lim, output int k, output bit saw_rst);
    k = 0; saw_rst = 0;
    while (!irq && k < lim) begin
      @(negedge clk); k++;
      if (rst_req) saw_rst = 1;
    end
  endtask

  task automatic wait_rst(input int lim, output int k);
    k = 0;
    while (!rst_req && k < lim) begin @(negedge clk); k++; end
  endtask

  task automatic idle(input int n, output bit saw_irq, output bit saw_rst);
    saw_irq = 0; saw_rst = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) saw_irq = 1;
      if (rst_req) saw_rst = 1;
    end
  endtask

  initial begin : watchdog
    wait (cyc >= 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, d16, c;
    int k, k2, seed, isel, rsel;
    bit sr, si;
    seed = 32'd4242;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst_req", {31'd0, rst_req}, 0);
    rd(A_CFG, d, d16); chk("R1 cfg", d, 0);
    rd(A_STA, d, d16); chk("R1 sta", d, 0);
    rd(A_WE, d, d16);  chk("R1 we", d, 0);

    // R10 ID constant, writes ignored
    rd(A_ID, d, d16); chk("R10 id", d, ID_V);
    wr(A_ID, 32'h1234_5678);
    rd(A_ID, d, d16); chk("R10 id after write", d, ID_V);

    // R2 unlock visible, other value relocks
    wr(A_WE, 32'h5AA5); rd(A_WE, d, d16); chk("R2 unlocked", d, 1);
    wr(A_WE, 32'h5AA4); rd(A_WE, d, d16); chk("R2 relocked", d, 0);

    // R3 locked cfg write ignored
    wr(A_CFG, 32'h7FF); rd(A_CFG, d, d16); chk("R3 locked cfg", d, 0);

    // R2 one-shot: second cfg write after one unlock is ignored
    c = mk_cfg(3, 2, 0, 0, 1) & ~32'h1;
    prot_wr(A_CFG, c);
    rd(A_WE, d, d16); chk("R2 consumed", d, 0);
    wr(A_CFG, 32'h0F5);
    rd(A_CFG, d, d16); chk("R4 fields readback", d, c);
    chk("R2 second write dropped", d, c);

    // R11 selector clamp
    prot_wr(A_CFG, 32'h0C0);
    rd(A_CFG, d, d16);
    chk("R11 32-bit keeps", d, 32'h0C0);
    chk("R11 16-bit clamps", d16, 32'h070);
    prot_wr(A_CFG, 0);

    // R5 R7 directed: shortest intervals, both stages on
    prot_wr(A_CFG, mk_cfg(0, 0, 1, 1, 0));
    wait_irq(5000, k, sr); chk("R5 first interval sel0", k, int_len(0));
    wait_rst(5000, k);     chk("R7 second interval sel0", k, rst_len(0));
    @(negedge clk); chk("R7 single pulse", {31'd0, rst_req}, 0);
    rd(A_STA, d, d16); chk("R6 flag set", d, 1);
    wr(A_STA, 0); rd(A_STA, d, d16); chk("R6 write 0 keeps", d, 1);
    wr(A_STA, 1); rd(A_STA, d, d16); chk("R6 write 1 clears", d, 0);

    // R3 locked restart in hold: irq stays
    wr(A_RS, 32'hCAFE); chk("R3 locked restart ignored", {31'd0, irq}, 1);
    // R8 valid restart drops irq and gives full interval
    prot_wr(A_RS, 32'hCAFE); chk("R8 restart drops irq", {31'd0, irq}, 0);
    wait_irq(5000, k, sr); chk("R8 full interval after restart", k, int_len(0));

    // R9 disable drops irq and stays quiet
    prot_wr(A_CFG, 0); chk("R9 disable drops irq", {31'd0, irq}, 0);
    idle(600, si, sr);
    chk("R9 no irq", {31'd0, si}, 0); chk("R9 no rst", {31'd0, sr}, 0);

    // R8 mid-interval restart
    prot_wr(A_CFG, mk_cfg(1, 0, 1, 1, 0));
    idle(150, si, sr);
    prot_wr(A_RS, 32'hCAFE);
    wait_irq(5000, k, sr); chk("R8 restart mid interval", k, int_len(1));
    prot_wr(A_CFG, 0);

    // R8 wrong key ignored
    prot_wr(A_CFG, mk_cfg(1, 0, 1, 1, 0));
    idle(150, si, sr);
    prot_wr(A_RS, 32'h1234);
    rd(A_WE, d, d16); chk("R2 consumed by bad restart", d, 0);
    wait_irq(5000, k, sr);
    chk("R8 bad key keeps count", {31'd0, (k <= 100)}, 1);
    prot_wr(A_CFG, 0);

    // R6 R7: interrupt stage off, reset stage off
    wr(A_STA, 1);
    prot_wr(A_CFG, mk_cfg(0, 0, 0, 0, 0));
    idle(64 + 128 + 20, si, sr);
    chk("R5 irq masked", {31'd0, si}, 0);
    chk("R7 reset stage off", {31'd0, sr}, 0);
    rd(A_STA, d, d16); chk("R6 flag without irq", d, 1);
    prot_wr(A_CFG, 0); wr(A_STA, 1);

    // random configurations
    for (int it = 0; it < 5; it++) begin
      isel = $urandom % 3;
      rsel = $urandom % 3;
      c = mk_cfg(isel, rsel, 1, 1, 1'($urandom % 2));
      prot_wr(A_CFG, c);
      wait_irq(20000, k, sr);
      wait_rst(20000, k2);
      chk($sformatf("R5 random sel%0d", isel), k, int_len(isel));
      chk($sformatf("R7 random sel%0d", rsel), k2, rst_len(rsel));
      @(negedge clk); chk("R7 random pulse width", {31'd0, rst_req}, 0);
      rd(A_CFG, d, d16); chk("R4 random readback", d, c);
      prot_wr(A_CFG, 0); wr(A_STA, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule